// File: doc/BRIEF.md
# Receive FIFO Read Port Controller

This block sits between a receive data queue of 32-bit words and the host's register read path. Words are pushed in from the receive side together with a flag that marks the final word of each buffer. The host pulls them out one read at a time. A companion status queue is carried alongside so that a single discard command can empty both. A 32-bit configuration register selects the tail alignment for each buffer, holds a word countdown for DMA pacing, and carries a one-shot discard command.

When the host reads the marked final word of a buffer, the block keeps offering zero-valued filler words. This continues until the number of words handed out for that buffer is a multiple of the selected alignment, so every buffer ends on a cache-line boundary. The host drops the filler. The alignment is latched at the first word of a buffer, so rewriting it mid-buffer only affects the next buffer.

Each real word read decrements the countdown. The read that takes the countdown from one to zero raises a sticky interrupt flag. A separate acknowledge input clears that flag.

Top module: `rxrd_port_ctrl`

## Requirements
- R1: After reset the configuration reads 0x00000000, both queues have level 0, `readAvail` is 0, `fillerActive` is 0 and `dmaIrq` is 0.
- R2: In the configuration register, bits 31:30 hold the alignment code and bits 27:16 hold the DMA count. Bits 29:28, bit 15 (discard) and bits 14:0 always read as 0.
- R3: While no filler is pending, `rdData` shows the oldest queued data word. An `rdEn` cycle removes that word and lowers `dataLevel` by one.
- R4: The alignment code selects a multiple of 1 word (code 00), 4 words (code 01) or 8 words (code 10). Code 11 behaves like 00. After the marked last word of a buffer is read, `fillerActive` is 1 and `rdData` is 0x00000000 for exactly the number of reads that brings the buffer's word total up to that multiple.
- R5: The alignment code in force when a buffer's first word is read applies to the whole buffer. A write to the alignment field after that has no effect on the buffer.
- R6: A filler read removes no word from the data queue and leaves the DMA count unchanged.
- R7: Every real word read with a nonzero DMA count lowers the count by one. At zero the count stays at zero. A configuration write in the same cycle takes precedence over the decrement.
- R8: `dmaIrq` rises on the cycle after a real word read takes the count from 1 to 0. Loading zero, and further reads at zero, raise nothing.
- R9: `dmaIrq` stays 1 until a cycle with `irqAck` high clears it.
- R10: A new count written before zero is reached replaces the running count, and the countdown continues from the new value.
- R11: A configuration write with bit 15 set empties both queues and drops any pending filler and partial-buffer progress. This takes priority over a push or read in the same cycle.
- R12: The status queue returns entries in push order through `statPop`. A push into a full queue is ignored.
- R13: An `rdEn` with no word and no filler available changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push a word into the data queue |
| pushData | input | 32 | Word to push |
| pushLast | input | 1 | Pushed word ends a buffer |
| statPushValid | input | 1 | Push an entry into the status queue |
| statPushData | input | 32 | Status entry to push |
| statPop | input | 1 | Remove the oldest status entry |
| statData | output | 32 | Oldest status entry |
| statLevel | output | 4 | Status queue occupancy |
| cfgWrEn | input | 1 | Write the configuration register |
| cfgWrData | input | 32 | Configuration write value |
| cfgRdData | output | 32 | Configuration read value |
| rdEn | input | 1 | Host read of one word |
| rdData | output | 32 | Word presented to the host |
| readAvail | output | 1 | A real or filler word is available |
| fillerActive | output | 1 | `rdData` is currently a filler word |
| dataLevel | output | 5 | Data queue occupancy |
| dmaIrq | output | 1 | Sticky DMA countdown interrupt |
| irqAck | input | 1 | Clear the interrupt |

## Verification
The assertions run on every cycle. They check that the interrupt only rises with the count at zero and holds until acknowledged, that a real read steps the count down by exactly one, and that a filler read leaves the count alone. They also check that pending filler never exceeds the latched alignment, that a discard leaves both queues empty on the next cycle, and that no queue exceeds its depth. Some properties need a whole buffer to be observed, and only the bench's scenarios can show them. These are the exact number of filler words for each alignment code and length, the locking of the alignment at the first word despite a mid-buffer rewrite, reload of the count before zero, and the ordering of data and status words.

// File: rtl/rxrd_pkg.sv
package rxrd_pkg;
  localparam int WORD_W      = 32;
  localparam int CNT_W       = 12;
  localparam int ALIGN_W     = 2;
  localparam int PAD_W       = 3;
  localparam int ALIGN_LSB   = 30;
  localparam int CNT_LSB     = 16;
  localparam int DISCARD_BIT = 15;

  typedef enum logic [ALIGN_W-1:0] {
    ALIGN_4B   = 2'b00,
    ALIGN_16B  = 2'b01,
    ALIGN_32B  = 2'b10,
    ALIGN_RSVD = 2'b11
  } alignSel_e;

  typedef struct packed {
    logic popData;
    logic popStat;
    logic flush;
    logic filler;
  } rdStrobe_t;

  function automatic logic [PAD_W:0] alignWords(alignSel_e sel);
    case (sel)
      ALIGN_16B: return (PAD_W+1)'(4);
      ALIGN_32B: return (PAD_W+1)'(8);
      default:   return (PAD_W+1)'(1);
    endcase
  endfunction

  function automatic logic [PAD_W-1:0] padNeeded(alignSel_e sel, logic [PAD_W-1:0] totalMod);
    logic [PAD_W:0]   span;
    logic [PAD_W-1:0] mask;
    span = alignWords(sel);
    mask = span[PAD_W-1:0] - 1'b1;
    return (~totalMod + 1'b1) & mask;
  endfunction
endpackage

// File: rtl/rxrd_fifo.sv
module rxrd_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [LW-1:0]    level,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign level    = wrPtr - rdPtr;
  assign empty    = (level == '0);
  assign full     = (level == LW'(DEPTH));
  assign doPush   = push & ~full & ~flush;
  assign doPop    = pop & ~empty & ~flush;
  assign headData = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr[AW-1:0]] <= pushData;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    level <= LW'(DEPTH)); // R12
  AST_FULL_PUSH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (full && !pop && !flush) |=> level == LW'(DEPTH)); // R12
endmodule

// File: rtl/rxrd_datapath.sv
module rxrd_datapath
  import rxrd_pkg::*;
#(
  parameter int DATA_DEPTH        = 16,
  parameter int STAT_DEPTH        = 8,
  parameter logic [WORD_W-1:0] FILL_WORD = '0,
  localparam int DLW = $clog2(DATA_DEPTH) + 1,
  localparam int SLW = $clog2(STAT_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         str,
  input  logic              pushValid,
  input  logic [WORD_W-1:0] pushData,
  input  logic              pushLast,
  input  logic              statPushValid,
  input  logic [WORD_W-1:0] statPushData,
  output logic [WORD_W-1:0] rdData,
  output logic              headLast,
  output logic              dataEmpty,
  output logic [DLW-1:0]    dataLevel,
  output logic [WORD_W-1:0] statData,
  output logic [SLW-1:0]    statLevel
);
  logic [WORD_W:0] dataHead;
  logic unusedFull0, unusedFull1, unusedStatEmpty;

  rxrd_fifo #(.WIDTH(WORD_W + 1), .DEPTH(DATA_DEPTH)) dataQ_i (
    .clk(clk), .rstN(rstN), .flush(str.flush),
    .push(pushValid), .pushData({pushLast, pushData}),
    .pop(str.popData), .headData(dataHead),
    .level(dataLevel), .empty(dataEmpty), .full(unusedFull0)
  );

  rxrd_fifo #(.WIDTH(WORD_W), .DEPTH(STAT_DEPTH)) statQ_i (
    .clk(clk), .rstN(rstN), .flush(str.flush),
    .push(statPushValid), .pushData(statPushData),
    .pop(str.popStat), .headData(statData),
    .level(statLevel), .empty(unusedStatEmpty), .full(unusedFull1)
  );

  assign headLast = dataHead[WORD_W];
  assign rdData   = str.filler ? FILL_WORD : dataHead[WORD_W-1:0];

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    str.flush |=> (dataLevel == '0) && (statLevel == '0)); // R11
endmodule

// File: rtl/rxrd_ctrl.sv
module rxrd_ctrl
  import rxrd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [WORD_W-1:0] cfgWrData,
  input  logic              rdEn,
  input  logic              statPop,
  input  logic              irqAck,
  input  logic              headLast,
  input  logic              dataEmpty,
  output rdStrobe_t         str,
  output logic [WORD_W-1:0] cfgRdData,
  output logic              dmaIrq,
  output logic              readAvail
);
  alignSel_e        cfgAlign, lockedAlign, effAlign, wrAlign;
  logic [CNT_W-1:0] dmaCnt;
  logic             inPkt, padActive;
  logic [PAD_W-1:0] pktWords, padRemain, padCalc;
  logic             flush, popReal, padStep;
  logic             unusedCfgBits;

  assign unusedCfgBits = ^{cfgWrData[ALIGN_LSB-1:CNT_LSB+CNT_W], cfgWrData[DISCARD_BIT-1:0]};

  assign wrAlign  = alignSel_e'(cfgWrData[ALIGN_LSB +: ALIGN_W]);
  assign flush    = cfgWrEn & cfgWrData[DISCARD_BIT];
  assign popReal  = rdEn & ~padActive & ~dataEmpty & ~flush;
  assign padStep  = rdEn & padActive & ~flush;
  assign effAlign = inPkt ? lockedAlign : cfgAlign;
  assign padCalc  = padNeeded(effAlign, pktWords + 1'b1);

  assign str.popData = popReal;
  assign str.popStat = statPop & ~flush;
  assign str.flush   = flush;
  assign str.filler  = padActive;
  assign readAvail   = padActive | ~dataEmpty;

  always_comb begin
    cfgRdData = '0;
    cfgRdData[ALIGN_LSB +: ALIGN_W] = cfgAlign;
    cfgRdData[CNT_LSB +: CNT_W]     = dmaCnt;
  end

  // configuration fields and countdown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAlign <= ALIGN_4B;
      dmaCnt   <= '0;
    end else if (cfgWrEn) begin
      cfgAlign <= wrAlign;
      dmaCnt   <= cfgWrData[CNT_LSB +: CNT_W];
    end else if (popReal && dmaCnt != '0) begin
      dmaCnt <= dmaCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaIrq <= 1'b0;
    end else if (popReal && !cfgWrEn && dmaCnt == CNT_W'(1)) begin
      dmaIrq <= 1'b1;
    end else if (irqAck) begin
      dmaIrq <= 1'b0;
    end
  end

  // packet progress and tail padding
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt       <= 1'b0;
      pktWords    <= '0;
      padRemain   <= '0;
      padActive   <= 1'b0;
      lockedAlign <= ALIGN_4B;
    end else if (flush) begin
      inPkt     <= 1'b0;
      pktWords  <= '0;
      padRemain <= '0;
      padActive <= 1'b0;
    end else if (popReal) begin
      if (!inPkt) lockedAlign <= cfgAlign;
      if (headLast) begin
        inPkt     <= 1'b0;
        pktWords  <= '0;
        padRemain <= padCalc;
        padActive <= (padCalc != '0);
      end else begin
        inPkt    <= 1'b1;
        pktWords <= pktWords + 1'b1;
      end
    end else if (padStep) begin
      padRemain <= padRemain - 1'b1;
      if (padRemain == PAD_W'(1)) padActive <= 1'b0;
    end
  end

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaIrq) |-> dmaCnt == '0); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (dmaIrq && !irqAck) |=> dmaIrq); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !padActive && !dataEmpty && !cfgWrEn && dmaCnt != '0)
      |=> dmaCnt == $past(dmaCnt) - CNT_W'(1)); // R7
  AST_FILLER_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rstN)
    (padActive && rdEn && !cfgWrEn) |=> $stable(dmaCnt)); // R6
  AST_PAD_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    padActive |-> ({1'b0, padRemain} < alignWords(lockedAlign))
                  || ({1'b0, padRemain} < alignWords(cfgAlign))); // R4
endmodule

// File: rtl/rxrd_port_ctrl.sv
module rxrd_port_ctrl
  import rxrd_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int STAT_DEPTH = 8,
  parameter logic [31:0] FILL_WORD = 32'h0000_0000,
  localparam int DLW = $clog2(DATA_DEPTH) + 1,
  localparam int SLW = $clog2(STAT_DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pushValid,
  input  logic [31:0]    pushData,
  input  logic           pushLast,
  input  logic           statPushValid,
  input  logic [31:0]    statPushData,
  input  logic           statPop,
  output logic [31:0]    statData,
  output logic [SLW-1:0] statLevel,
  input  logic           cfgWrEn,
  input  logic [31:0]    cfgWrData,
  output logic [31:0]    cfgRdData,
  input  logic           rdEn,
  output logic [31:0]    rdData,
  output logic           readAvail,
  output logic           fillerActive,
  output logic [DLW-1:0] dataLevel,
  output logic           dmaIrq,
  input  logic           irqAck
);
  rdStrobe_t str;
  logic headLast, dataEmpty;

  rxrd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .rdEn(rdEn), .statPop(statPop), .irqAck(irqAck),
    .headLast(headLast), .dataEmpty(dataEmpty), .str(str),
    .cfgRdData(cfgRdData), .dmaIrq(dmaIrq), .readAvail(readAvail)
  );

  rxrd_datapath #(.DATA_DEPTH(DATA_DEPTH), .STAT_DEPTH(STAT_DEPTH), .FILL_WORD(FILL_WORD)) dp_i (
    .clk(clk), .rstN(rstN), .str(str),
    .pushValid(pushValid), .pushData(pushData), .pushLast(pushLast),
    .statPushValid(statPushValid), .statPushData(statPushData),
    .rdData(rdData), .headLast(headLast), .dataEmpty(dataEmpty),
    .dataLevel(dataLevel), .statData(statData), .statLevel(statLevel)
  );

  assign fillerActive = str.filler;
endmodule

// File: tb/rxrd_port_ctrl_tb_top.sv
module rxrd_port_ctrl_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic pushValid = 0, pushLast = 0, statPushValid = 0, statPop = 0;
  logic cfgWrEn = 0, rdEn = 0, irqAck = 0;
  logic [31:0] pushData = 0, statPushData = 0, cfgWrData = 0;
  logic [31:0] statData, cfgRdData, rdData;
  logic [3:0] statLevel;
  logic [4:0] dataLevel;
  logic readAvail, fillerActive, dmaIrq;
  int nTests = 0, nFail = 0;

  always #4 clk = ~clk;

  rxrd_port_ctrl dut_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData), .pushLast(pushLast),
    .statPushValid(statPushValid), .statPushData(statPushData), .statPop(statPop),
    .statData(statData), .statLevel(statLevel), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .rdEn(rdEn), .rdData(rdData), .readAvail(readAvail),
    .fillerActive(fillerActive), .dataLevel(dataLevel), .dmaIrq(dmaIrq), .irqAck(irqAck)
  );

  function automatic int expPad(logic [1:0] code, int len);
    int span = (code == 2'b01) ? 4 : (code == 2'b10) ? 8 : 1;
    return (span - (len % span)) % span;
  endfunction

  function automatic logic [31:0] cfgWord(logic [1:0] a, logic [11:0] c, bit disc);
    return {a, 2'b00, c, disc, 15'h0};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [1:0] a, logic [11:0] c, bit disc);
    cfgWrEn = 1; cfgWrData = cfgWord(a, c, disc);
    @(negedge clk); cfgWrEn = 0;
  endtask

  task automatic pushWord(logic [31:0] d, bit last);
    pushValid = 1; pushData = d; pushLast = last;
    @(negedge clk); pushValid = 0; pushLast = 0;
  endtask

  task automatic pushStat(logic [31:0] d);
    statPushValid = 1; statPushData = d;
    @(negedge clk); statPushValid = 0;
  endtask

  task automatic readWord(output logic [31:0] d, output logic f);
    d = rdData; f = fillerActive;
    rdEn = 1;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic ack();
    irqAck = 1; @(negedge clk); irqAck = 0;
  endtask

  // push a buffer of len words (base+i), then read it and its filler
  task automatic runPacket(string req, logic [1:0] code, int len, logic [31:0] base);
    logic [31:0] d; logic f;
    int pad = expPad(code, len);
    for (int i = 0; i < len; i++) pushWord(base + i, i == len - 1);
    for (int i = 0; i < len + pad; i++) begin
      readWord(d, f);
      chk(req, "word value", d, (i < len) ? base + i : 32'h0);
      chk(req, "filler flag", {31'h0, f}, {31'h0, i >= len});
    end
    chk(req, "nothing left after padding", {31'h0, readAvail}, 32'h0);
  endtask

  initial begin
    logic [31:0] d; logic f;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "cfg", cfgRdData, 32'h0);
    chk("R1", "dataLevel", {27'h0, dataLevel}, 32'h0);
    chk("R1", "statLevel", {28'h0, statLevel}, 32'h0);
    chk("R1", "readAvail/filler/irq", {29'h0, readAvail, fillerActive, dmaIrq}, 32'h0);

    // R2 field layout, reserved and discard bits read zero
    cfgWrEn = 1; cfgWrData = 32'hBABC_7FFF; @(negedge clk); cfgWrEn = 0;
    chk("R2", "readback", cfgRdData, 32'h8ABC_0000);
    cfgWrite(2'b00, 12'h0, 0);

    // R3, R4, R6: code 01, 3 words -> 1 filler; count drops by 3 only
    cfgWrite(2'b01, 12'd10, 0);
    pushWord(32'hA0, 0); pushWord(32'hA1, 0);
    chk("R3", "level after push", {27'h0, dataLevel}, 32'd2);
    chk("R3", "head word", rdData, 32'hA0);
    pushWord(32'hA2, 1);
    readWord(d, f);
    chk("R3", "level after read", {27'h0, dataLevel}, 32'd2);
    readWord(d, f); readWord(d, f);
    chk("R4", "filler after last", {31'h0, fillerActive}, 32'h1);
    chk("R4", "filler value", rdData, 32'h0);
    readWord(d, f);
    chk("R6", "count ignores filler", {20'h0, cfgRdData[27:16]}, 32'd7);
    chk("R4", "padding done", {31'h0, fillerActive}, 32'h0);

    // R4 reserved code and 32-byte alignment
    cfgWrite(2'b11, 12'd0, 0);
    runPacket("R4", 2'b11, 3, 32'h100);
    cfgWrite(2'b10, 12'd0, 0);
    runPacket("R4", 2'b10, 1, 32'h200);
    runPacket("R4", 2'b10, 8, 32'h300);

    // R5 alignment locked at first word
    cfgWrite(2'b10, 12'd0, 0);
    pushWord(32'h50, 0); pushWord(32'h51, 0); pushWord(32'h52, 1);
    readWord(d, f);
    cfgWrite(2'b00, 12'd0, 0);
    readWord(d, f); readWord(d, f);
    for (int i = 0; i < 5; i++) begin
      chk("R5", "filler from locked code", {31'h0, fillerActive}, 32'h1);
      readWord(d, f);
    end
    chk("R5", "filler ends after 5", {31'h0, readAvail}, 32'h0);

    // R7, R8, R9 countdown and interrupt
    cfgWrite(2'b00, 12'd2, 0);
    for (int i = 0; i < 4; i++) pushWord(32'h60 + i, i == 3);
    readWord(d, f);
    chk("R8", "no irq at 1", {31'h0, dmaIrq}, 32'h0);
    readWord(d, f);
    chk("R8", "irq at zero", {31'h0, dmaIrq}, 32'h1);
    readWord(d, f);
    chk("R7", "count holds at zero", {20'h0, cfgRdData[27:16]}, 32'h0);
    chk("R9", "irq sticky", {31'h0, dmaIrq}, 32'h1);
    ack();
    chk("R9", "irq cleared", {31'h0, dmaIrq}, 32'h0);
    readWord(d, f);
    chk("R8", "no retrigger at zero", {31'h0, dmaIrq}, 32'h0);

    // R8 zero load; R10 reload before zero
    cfgWrite(2'b00, 12'd0, 0);
    chk("R8", "zero load no irq", {31'h0, dmaIrq}, 32'h0);
    cfgWrite(2'b00, 12'd5, 0);
    for (int i = 0; i < 3; i++) pushWord(32'h70 + i, i == 2);
    readWord(d, f);
    cfgWrite(2'b00, 12'd2, 0);
    chk("R10", "reloaded count", {20'h0, cfgRdData[27:16]}, 32'd2);
    readWord(d, f);
    chk("R10", "no irq at 1", {31'h0, dmaIrq}, 32'h0);
    readWord(d, f);
    chk("R10", "irq from new count", {31'h0, dmaIrq}, 32'h1);
    ack();

    // R11 discard mid-buffer, with pending filler, and against same-cycle push
    for (int i = 0; i < 4; i++) pushWord(32'h80 + i, i == 3);
    pushStat(32'h5A); pushStat(32'h5B);
    readWord(d, f);
    cfgWrite(2'b10, 12'd0, 1);
    chk("R11", "data emptied", {27'h0, dataLevel}, 32'h0);
    chk("R11", "status emptied", {28'h0, statLevel}, 32'h0);
    chk("R11", "nothing available", {31'h0, readAvail}, 32'h0);
    chk("R11", "discard bit reads 0", cfgRdData, 32'h8000_0000);
    pushWord(32'h90, 1);
    readWord(d, f);
    chk("R11", "filler pending", {31'h0, fillerActive}, 32'h1);
    cfgWrite(2'b00, 12'd0, 1);
    chk("R11", "filler dropped", {30'h0, fillerActive, readAvail}, 32'h0);
    pushValid = 1; pushData = 32'h91; pushLast = 1;
    cfgWrEn = 1; cfgWrData = cfgWord(2'b00, 12'd0, 1);
    @(negedge clk); pushValid = 0; cfgWrEn = 0; pushLast = 0;
    chk("R11", "discard beats push", {27'h0, dataLevel}, 32'h0);
    runPacket("R11", 2'b00, 1, 32'hA00);

    // R12 status order and full queue
    pushStat(32'h11); pushStat(32'h22); pushStat(32'h33);
    for (int i = 0; i < 3; i++) begin
      chk("R12", "status order", statData, 32'h11 * (i + 1));
      statPop = 1; @(negedge clk); statPop = 0;
    end
    for (int i = 0; i < 17; i++) pushWord(32'hB0 + i, 0);
    chk("R12", "full push ignored", {27'h0, dataLevel}, 32'd16);
    cfgWrite(2'b00, 12'd0, 1);

    // R13 empty read
    cfgWrite(2'b00, 12'd3, 0);
    readWord(d, f);
    chk("R13", "count unchanged", {20'h0, cfgRdData[27:16]}, 32'd3);
    chk("R13", "no filler/level", {26'h0, dataLevel, fillerActive}, 32'h0);
    pushWord(32'hC0, 1);
    chk("R13", "next word intact", rdData, 32'hC0);
    readWord(d, f);

    // random buffers: R4 R7 R8
    for (int p = 0; p < 40; p++) begin
      logic [1:0] code = 2'($urandom % 4);
      int len = 1 + ($urandom % 10);
      int cnt = $urandom % 16;
      int remain;
      cfgWrite(code, 12'(cnt), 0);
      runPacket("R4", code, len, $urandom);
      remain = (cnt > len) ? cnt - len : 0;
      chk("R7", "random count", {20'h0, cfgRdData[27:16]}, 32'(remain));
      chk("R8", "random irq", {31'h0, dmaIrq}, {31'h0, cnt != 0 && cnt <= len});
      ack();
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule